// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the output timing of a progressive display from a small set of coarse register values. A pixel counter and a line counter are both referenced to the leading edges of the incoming line and frame sync pulses. From these two counts the block derives an output line sync, an output frame sync, a visible (non-blanked) window and a capture window. The part of the visible area that lies outside the capture window is flagged as border, so the downstream pixel path can fill it with a flat colour.

Every horizontal edge is given in units of 8 pixels and every vertical edge in units of 4 lines. The line length is assembled from two fields with an implied zero least significant bit. Any window whose start lies beyond its end wraps across the end of the line or frame. With software timing off, one of four built-in presets is used, chosen by a two-bit mode input. Whichever set is chosen, it is captured only at a frame boundary, so a write made mid-frame never produces a partial frame.

Top module: `raster_timing_top`

## Requirements
- R1: During and directly after reset, the capture, border and visible outputs are 0, the measured frame length reads 0, and each output sync pin sits at its inactive level, which is the inverse of its polarity input.
- R2: The pixel count returns to 0 on the cycle after a leading edge of the input line sync. A horizontal window given by coarse start S and end E covers pixel counts from S*8 up to E*8-1. The registered output line sync follows the pixel count with a delay of one cycle.
- R3: The line length is {length_hi, length_lo, 0}: length_hi supplies bits 10:3 and length_lo supplies bits 2:1. With no input line sync, the pixel count still runs 0 .. length-1 and then wraps to 0.
- R4: The line count advances by one on each line start, meaning an input line sync leading edge or a pixel count wrap. It returns to 0 on a leading edge of the input frame sync, which takes priority. A vertical window with coarse start S and end E covers line counts S*4 up to E*4-1. The output frame sync follows the line count alone.
- R5: When start > end, a window is active at counts >= start or < end. When start == end, it is never active.
- R6: Each output sync pin is active-high when its polarity input is 1 and active-low when it is 0.
- R7: Each input sync is taken as active-high when its polarity input is 1 and active-low when 0. Its leading edge is the change from inactive to active.
- R8: href_o is high when both the horizontal and the vertical visible windows hold. cap_o is high when both capture windows hold. border_o is high when href_o would be high and cap_o would be low. All three are registered, one cycle after the counts.
- R9: With soft_time = 0, the timing comes from the preset picked by mode_sel. Pixel values are given as h ranges and line values as v ranges, with end exclusive. 0 (CCIR NTSC): length 858, capture h 72..752 v 48..500, hsync 792..856, visible h 48..776 v 40..508. 1 (CCIR PAL): length 864, capture h 80..760 v 60..604, hsync 808..16, visible h 56..784 v 52..612. 2 (square NTSC): length 780, capture h 120..736 v 48..500, hsync 776..56, visible h 96..760 v 40..508. 3 (square PAL): length 944, capture h 160..896 v 60..604, hsync 0..72, visible h 136..920 v 52..612. Every preset uses vsync lines 4..8. Reset loads preset 0.
- R10: The register values, soft_time and mode_sel take effect only on the cycle after an input frame sync leading edge. Between such edges, the timing in use stays unchanged.
- R11: On each input frame sync leading edge, vtot_o takes the line count plus one. This is the number of lines since the previous leading edge, and vtot_o holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_hs | input | 1 | Input line sync |
| in_vs | input | 1 | Input frame sync |
| in_hs_pol | input | 1 | Input line sync polarity (1 = active-high) |
| in_vs_pol | input | 1 | Input frame sync polarity (1 = active-high) |
| out_hs_pol | input | 1 | Output line sync polarity (1 = active-high) |
| out_vs_pol | input | 1 | Output frame sync polarity (1 = active-high) |
| soft_time | input | 1 | 1: take timing from the cfg inputs; 0: from a preset |
| mode_sel | input | 2 | Preset choice when soft_time is 0 |
| cfg_hcap_start | input | 8 | Horizontal capture start, 8-pixel units |
| cfg_hcap_end | input | 8 | Horizontal capture end, 8-pixel units |
| cfg_hsync_start | input | 8 | Output line sync start, 8-pixel units |
| cfg_hsync_end | input | 8 | Output line sync end, 8-pixel units |
| cfg_hvis_start | input | 8 | Horizontal visible start, 8-pixel units |
| cfg_hvis_end | input | 8 | Horizontal visible end, 8-pixel units |
| cfg_htot_hi | input | 8 | Line length bits 10:3 |
| cfg_htot_lo | input | 2 | Line length bits 2:1 |
| cfg_vcap_start | input | 8 | Vertical capture start, 4-line units |
| cfg_vcap_end | input | 8 | Vertical capture end, 4-line units |
| cfg_vsync_start | input | 8 | Output frame sync start, 4-line units |
| cfg_vsync_end | input | 8 | Output frame sync end, 4-line units |
| cfg_vvis_start | input | 8 | Vertical visible start, 4-line units |
| cfg_vvis_end | input | 8 | Vertical visible end, 4-line units |
| out_hs | output | 1 | Output line sync |
| out_vs | output | 1 | Output frame sync |
| href_o | output | 1 | Visible (non-blanked) window |
| cap_o | output | 1 | Capture window |
| border_o | output | 1 | Visible but outside capture |
| vtot_o | output | 10 | Measured lines per frame |

## Verification
The hardest situation to reach is a timing change that arrives in the middle of a frame and must stay invisible until the next frame sync edge. Reaching it needs register or mode updates timed between sync pulses, followed by a later frame edge. The stimulus rewrites the random soft register set and the preset mode while a frame is running. A reference model in the bench latches only on its own detected frame edges, and every output is compared each cycle against that model. Wrapping and empty windows arise from random coarse values drawn across the whole line. A directed frame with the input line sync switched off exercises the free-running wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   localparam int RTG_REG_W = 8;
   localparam int RTG_HTL_W = 2;

   typedef logic [RTG_REG_W-1:0] rtg_coarse_t;

   typedef enum logic [1:0] {
      RTG_CCIR_NTSC = 2'd0,
      RTG_CCIR_PAL  = 2'd1,
      RTG_SQ_NTSC   = 2'd2,
      RTG_SQ_PAL    = 2'd3
   } rtg_mode_e;

   // one complete timing set, all edges in coarse units
   typedef struct packed {
      rtg_coarse_t hcap_s;
      rtg_coarse_t hcap_e;
      rtg_coarse_t hsy_s;
      rtg_coarse_t hsy_e;
      rtg_coarse_t hvis_s;
      rtg_coarse_t hvis_e;
      rtg_coarse_t ht_hi;
      logic [RTG_HTL_W-1:0] ht_lo;
      rtg_coarse_t vcap_s;
      rtg_coarse_t vcap_e;
      rtg_coarse_t vsy_s;
      rtg_coarse_t vsy_e;
      rtg_coarse_t vvis_s;
      rtg_coarse_t vvis_e;
   } rtg_set_t;

   function automatic rtg_set_t rtg_mk(
      input rtg_coarse_t hcs, input rtg_coarse_t hce,
      input rtg_coarse_t hss, input rtg_coarse_t hse,
      input rtg_coarse_t hvs, input rtg_coarse_t hve,
      input rtg_coarse_t hth, input logic [RTG_HTL_W-1:0] htl,
      input rtg_coarse_t vcs, input rtg_coarse_t vce,
      input rtg_coarse_t vss, input rtg_coarse_t vse,
      input rtg_coarse_t vvs, input rtg_coarse_t vve);
      rtg_set_t s;
      s.hcap_s = hcs;  s.hcap_e = hce;
      s.hsy_s  = hss;  s.hsy_e  = hse;
      s.hvis_s = hvs;  s.hvis_e = hve;
      s.ht_hi  = hth;  s.ht_lo  = htl;
      s.vcap_s = vcs;  s.vcap_e = vce;
      s.vsy_s  = vss;  s.vsy_e  = vse;
      s.vvis_s = vvs;  s.vvis_e = vve;
      return s;
   endfunction

   // built-in presets, coarse units
   function automatic rtg_set_t rtg_preset(input rtg_mode_e m);
      rtg_set_t s;
      case (m)
         RTG_CCIR_PAL:
            s = rtg_mk(8'h0A, 8'h5F, 8'h65, 8'h02, 8'h07, 8'h62, 8'h6C, 2'd0,
                       8'h0F, 8'h97, 8'h01, 8'h02, 8'h0D, 8'h99);
         RTG_SQ_NTSC:
            s = rtg_mk(8'h0F, 8'h5C, 8'h61, 8'h07, 8'h0C, 8'h5F, 8'h61, 2'd2,
                       8'h0C, 8'h7D, 8'h01, 8'h02, 8'h0A, 8'h7F);
         RTG_SQ_PAL:
            s = rtg_mk(8'h14, 8'h70, 8'h00, 8'h09, 8'h11, 8'h73, 8'h76, 2'd0,
                       8'h0F, 8'h97, 8'h01, 8'h02, 8'h0D, 8'h99);
         default:
            s = rtg_mk(8'h09, 8'h5E, 8'h63, 8'h6B, 8'h06, 8'h61, 8'h6B, 2'd1,
                       8'h0C, 8'h7D, 8'h01, 8'h02, 8'h0A, 8'h7F);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/rtg_sync_edge.sv
module rtg_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic pol_i,
   output logic lead_o
);
   logic act;
   logic act_q;

   assign act = pol_i ? sync_i : ~sync_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   assign lead_o = act & ~act_q;
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
   parameter int W = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         adv_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   logic [W-1:0] last;

   // a limit of zero wraps at the all-ones value
   assign last   = limit_i - W'(1);
   assign wrap_o = adv_i & ~clear_i & (cnt_o == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_o <= '0;
      else if (clear_i) cnt_o <= '0;
      else if (wrap_o)  cnt_o <= '0;
      else if (adv_i)   cnt_o <= cnt_o + W'(1);
   end
endmodule

// File: rtl/rtg_window.sv
module rtg_window
   import rtg_pkg::*;
#(
   parameter int SHIFT   = 3,
   parameter bit WRAP_OK = 1'b1,
   localparam int W      = RTG_REG_W + SHIFT
) (
   input  logic [W-1:0]   cnt_i,
   input  rtg_coarse_t    start_i,
   input  rtg_coarse_t    end_i,
   output logic           in_o
);
   logic [W-1:0] pos_s;
   logic [W-1:0] pos_e;

   assign pos_s = {start_i, {SHIFT{1'b0}}};
   assign pos_e = {end_i,   {SHIFT{1'b0}}};

   generate
      if (WRAP_OK) begin : g_wrap
         always_comb begin
            if (pos_s <= pos_e) in_o = (cnt_i >= pos_s) && (cnt_i < pos_e);
            else                in_o = (cnt_i >= pos_s) || (cnt_i < pos_e);
         end
      end else begin : g_plain
         assign in_o = (cnt_i >= pos_s) && (cnt_i < pos_e);
      end
   endgenerate
endmodule

// File: rtl/rtg_shadow.sv
module rtg_shadow
   import rtg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic       soft_i,
   input  logic [1:0] mode_i,
   input  rtg_set_t   soft_set_i,
   output rtg_set_t   act_o
);
   rtg_set_t next_set;

   assign next_set = soft_i ? soft_set_i : rtg_preset(rtg_mode_e'(mode_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_o <= rtg_preset(RTG_CCIR_NTSC);
      else if (load_i) act_o <= next_set;
   end
endmodule

// File: rtl/raster_timing_top.sv
module raster_timing_top
   import rtg_pkg::*;
#(
   parameter int H_SHIFT      = 3,
   parameter int V_SHIFT      = 2,
   parameter bit WRAP_WINDOWS = 1'b1,
   localparam int H_CW        = RTG_REG_W + H_SHIFT,
   localparam int V_CW        = RTG_REG_W + V_SHIFT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_hs,
   input  logic            in_vs,
   input  logic            in_hs_pol,
   input  logic            in_vs_pol,
   input  logic            out_hs_pol,
   input  logic            out_vs_pol,
   input  logic            soft_time,
   input  logic [1:0]      mode_sel,
   input  logic [7:0]      cfg_hcap_start,
   input  logic [7:0]      cfg_hcap_end,
   input  logic [7:0]      cfg_hsync_start,
   input  logic [7:0]      cfg_hsync_end,
   input  logic [7:0]      cfg_hvis_start,
   input  logic [7:0]      cfg_hvis_end,
   input  logic [7:0]      cfg_htot_hi,
   input  logic [1:0]      cfg_htot_lo,
   input  logic [7:0]      cfg_vcap_start,
   input  logic [7:0]      cfg_vcap_end,
   input  logic [7:0]      cfg_vsync_start,
   input  logic [7:0]      cfg_vsync_end,
   input  logic [7:0]      cfg_vvis_start,
   input  logic [7:0]      cfg_vvis_end,
   output logic            out_hs,
   output logic            out_vs,
   output logic            href_o,
   output logic            cap_o,
   output logic            border_o,
   output logic [V_CW-1:0] vtot_o
);
   localparam int N_WIN   = 3;
   localparam int WIN_CAP = 0;
   localparam int WIN_SYN = 1;
   localparam int WIN_VIS = 2;

   generate
      if (H_SHIFT != RTG_HTL_W + 1) begin : g_bad_hshift
         $error("H_SHIFT must equal the line length low field width plus one");
      end
      if (V_SHIFT < 1) begin : g_bad_vshift
         $error("V_SHIFT must be at least one");
      end
   endgenerate

   logic            hs_lead;
   logic            vs_lead;
   logic            h_wrap;
   logic            v_wrap_unused;
   logic            line_start;
   logic [H_CW-1:0] h_cnt;
   logic [V_CW-1:0] v_cnt;
   logic [H_CW-1:0] h_limit;
   rtg_set_t        soft_set;
   rtg_set_t        act;

   // ---------------- sync edge detection ----------------
   rtg_sync_edge u_hs_edge (
      .clk(clk), .rst_n(rst_n), .sync_i(in_hs), .pol_i(in_hs_pol), .lead_o(hs_lead)
   );
   rtg_sync_edge u_vs_edge (
      .clk(clk), .rst_n(rst_n), .sync_i(in_vs), .pol_i(in_vs_pol), .lead_o(vs_lead)
   );

   // ---------------- timing set selection ----------------
   assign soft_set = rtg_mk(cfg_hcap_start, cfg_hcap_end, cfg_hsync_start, cfg_hsync_end,
                            cfg_hvis_start, cfg_hvis_end, cfg_htot_hi, cfg_htot_lo,
                            cfg_vcap_start, cfg_vcap_end, cfg_vsync_start, cfg_vsync_end,
                            cfg_vvis_start, cfg_vvis_end);

   rtg_shadow u_shadow (
      .clk(clk), .rst_n(rst_n), .load_i(vs_lead), .soft_i(soft_time),
      .mode_i(mode_sel), .soft_set_i(soft_set), .act_o(act)
   );

   // ---------------- counters ----------------
   assign h_limit = {act.ht_hi, act.ht_lo, 1'b0};

   rtg_counter #(.W(H_CW)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .clear_i(hs_lead), .adv_i(1'b1),
      .limit_i(h_limit), .cnt_o(h_cnt), .wrap_o(h_wrap)
   );

   assign line_start = hs_lead | h_wrap;

   rtg_counter #(.W(V_CW)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .clear_i(vs_lead), .adv_i(line_start),
      .limit_i('0), .cnt_o(v_cnt), .wrap_o(v_wrap_unused)
   );

   // ---------------- window decode ----------------
   rtg_coarse_t [N_WIN-1:0] hw_s, hw_e, vw_s, vw_e;
   logic        [N_WIN-1:0] h_in, v_in;

   assign hw_s[WIN_CAP] = act.hcap_s;  assign hw_e[WIN_CAP] = act.hcap_e;
   assign hw_s[WIN_SYN] = act.hsy_s;   assign hw_e[WIN_SYN] = act.hsy_e;
   assign hw_s[WIN_VIS] = act.hvis_s;  assign hw_e[WIN_VIS] = act.hvis_e;
   assign vw_s[WIN_CAP] = act.vcap_s;  assign vw_e[WIN_CAP] = act.vcap_e;
   assign vw_s[WIN_SYN] = act.vsy_s;   assign vw_e[WIN_SYN] = act.vsy_e;
   assign vw_s[WIN_VIS] = act.vvis_s;  assign vw_e[WIN_VIS] = act.vvis_e;

   generate
      for (genvar g = 0; g < N_WIN; g++) begin : g_win
         rtg_window #(.SHIFT(H_SHIFT), .WRAP_OK(WRAP_WINDOWS)) u_hwin (
            .cnt_i(h_cnt), .start_i(hw_s[g]), .end_i(hw_e[g]), .in_o(h_in[g])
         );
         rtg_window #(.SHIFT(V_SHIFT), .WRAP_OK(WRAP_WINDOWS)) u_vwin (
            .cnt_i(v_cnt), .start_i(vw_s[g]), .end_i(vw_e[g]), .in_o(v_in[g])
         );
      end
   endgenerate

   // ---------------- registered outputs ----------------
   logic            vis_now;
   logic            cap_now;
   logic            hs_q, vs_q, vis_q, cap_q, brd_q;
   logic [V_CW-1:0] vtot_q;

   assign vis_now = h_in[WIN_VIS] & v_in[WIN_VIS];
   assign cap_now = h_in[WIN_CAP] & v_in[WIN_CAP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         vs_q  <= 1'b0;
         vis_q <= 1'b0;
         cap_q <= 1'b0;
         brd_q <= 1'b0;
      end else begin
         hs_q  <= h_in[WIN_SYN];
         vs_q  <= v_in[WIN_SYN];
         vis_q <= vis_now;
         cap_q <= cap_now;
         brd_q <= vis_now & ~cap_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vtot_q <= '0;
      else if (vs_lead) vtot_q <= v_cnt + V_CW'(1);
   end

   assign out_hs   = out_hs_pol ? hs_q : ~hs_q;
   assign out_vs   = out_vs_pol ? vs_q : ~vs_q;
   assign href_o   = vis_q;
   assign cap_o    = cap_q;
   assign border_o = brd_q;
   assign vtot_o   = vtot_q;
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
   import rtg_pkg::*;
#(
   parameter int H_CW = 11,
   parameter int V_CW = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            hs_lead,
   input logic            vs_lead,
   input logic [H_CW-1:0] h_cnt,
   input logic [V_CW-1:0] v_cnt,
   input logic [H_CW-1:0] h_limit,
   input rtg_set_t        act_set,
   input logic [V_CW-1:0] vtot
);
   // R2
   hs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_lead |=> (h_cnt == '0));

   // R3
   h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_lead && (h_cnt == H_CW'(h_limit - 1'b1))) |=> (h_cnt == '0));

   // R3
   h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_lead && (h_cnt != H_CW'(h_limit - 1'b1))) |=> (h_cnt == H_CW'($past(h_cnt) + 1'b1)));

   // R4
   vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vs_lead |=> (v_cnt == '0));

   // R10
   set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_lead |=> $stable(act_set));

   // R11
   vtot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_lead |=> $stable(vtot));
endmodule

bind raster_timing_top rtg_chk #(.H_CW(H_CW), .V_CW(V_CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
   .h_cnt(h_cnt), .v_cnt(v_cnt), .h_limit(h_limit), .act_set(act), .vtot(vtot_o)
);

// File: tb/raster_timing_top_tb_top.sv
`timescale 1ns/1ps
module raster_timing_top_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic in_hs, in_vs, in_hs_pol, in_vs_pol, out_hs_pol, out_vs_pol, soft_time;
   logic [1:0] mode_sel;
   logic [7:0] c_hcs, c_hce, c_hss, c_hse, c_hvs, c_hve, c_hth;
   logic [1:0] c_htl;
   logic [7:0] c_vcs, c_vce, c_vss, c_vse, c_vvs, c_vve;
   logic out_hs, out_vs, href_o, cap_o, border_o;
   logic [9:0] vtot_o;

   always #2.5 clk = ~clk;

   raster_timing_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_hs(in_hs), .in_vs(in_vs),
      .in_hs_pol(in_hs_pol), .in_vs_pol(in_vs_pol),
      .out_hs_pol(out_hs_pol), .out_vs_pol(out_vs_pol),
      .soft_time(soft_time), .mode_sel(mode_sel),
      .cfg_hcap_start(c_hcs), .cfg_hcap_end(c_hce),
      .cfg_hsync_start(c_hss), .cfg_hsync_end(c_hse),
      .cfg_hvis_start(c_hvs), .cfg_hvis_end(c_hve),
      .cfg_htot_hi(c_hth), .cfg_htot_lo(c_htl),
      .cfg_vcap_start(c_vcs), .cfg_vcap_end(c_vce),
      .cfg_vsync_start(c_vss), .cfg_vsync_end(c_vse),
      .cfg_vvis_start(c_vvs), .cfg_vvis_end(c_vve),
      .out_hs(out_hs), .out_vs(out_vs), .href_o(href_o), .cap_o(cap_o),
      .border_o(border_o), .vtot_o(vtot_o)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    mon_en = 1'b0;
   string cur_tag = "R1";

   task automatic check(input bit ok, input string req, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, cur_tag, $time, actv, expv);
      end
   endtask

   // ---------------- reference model, pixel units ----------------
   typedef struct {
      int htot; int hcs; int hce; int hss; int hse; int hvs; int hve;
      int vcs; int vce; int vss; int vse; int vvs; int vve;
   } pset_t;

   function automatic pset_t preset_px(input int m);
      case (m)
         1:       return '{864, 80, 760, 808, 16, 56, 784, 60, 604, 4, 8, 52, 612};
         2:       return '{780, 120, 736, 776, 56, 96, 760, 48, 500, 4, 8, 40, 508};
         3:       return '{944, 160, 896, 0, 72, 136, 920, 60, 604, 4, 8, 52, 612};
         default: return '{858, 72, 752, 792, 856, 48, 776, 48, 500, 4, 8, 40, 508};
      endcase
   endfunction

   function automatic pset_t soft_px();
      pset_t p;
      p.htot = int'(c_hth) * 8 + int'(c_htl) * 2;
      p.hcs = int'(c_hcs) * 8; p.hce = int'(c_hce) * 8;
      p.hss = int'(c_hss) * 8; p.hse = int'(c_hse) * 8;
      p.hvs = int'(c_hvs) * 8; p.hve = int'(c_hve) * 8;
      p.vcs = int'(c_vcs) * 4; p.vce = int'(c_vce) * 4;
      p.vss = int'(c_vss) * 4; p.vse = int'(c_vse) * 4;
      p.vvs = int'(c_vvs) * 4; p.vve = int'(c_vve) * 4;
      return p;
   endfunction

   function automatic bit win(input int c, input int s, input int e);
      if (s <= e) return (c >= s) && (c < e);
      return (c >= s) || (c < e);
   endfunction

   pset_t act_m;
   int    hm, vm, vtm;
   bit    hs_prev, vs_prev;
   bit    e_hs, e_vs, e_vis, e_cap, e_brd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_m = preset_px(0);
         hm = 0; vm = 0; vtm = 0;
         hs_prev = 0; vs_prev = 0;
         e_hs = 0; e_vs = 0; e_vis = 0; e_cap = 0; e_brd = 0;
      end else begin
         bit ah, av, hl, vl, hw;
         e_hs  = win(hm, act_m.hss, act_m.hse);
         e_vs  = win(vm, act_m.vss, act_m.vse);
         e_vis = win(hm, act_m.hvs, act_m.hve) && win(vm, act_m.vvs, act_m.vve);
         e_cap = win(hm, act_m.hcs, act_m.hce) && win(vm, act_m.vcs, act_m.vce);
         e_brd = e_vis && !e_cap;
         ah = in_hs_pol ? in_hs : !in_hs;
         av = in_vs_pol ? in_vs : !in_vs;
         hl = ah && !hs_prev;
         vl = av && !vs_prev;
         hs_prev = ah; vs_prev = av;
         hw = !hl && (hm == ((act_m.htot - 1) & 2047));
         if (vl) vtm = (vm + 1) & 1023;
         if (vl)            vm = 0;
         else if (hl || hw) vm = (vm + 1) & 1023;
         if (hl || hw) hm = 0;
         else          hm = (hm + 1) & 2047;
         if (vl) act_m = soft_time ? soft_px() : preset_px(int'(mode_sel));
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && mon_en && !done) begin
         check(out_hs === (out_hs_pol ? e_hs : !e_hs), "R2 R6", int'(out_hs), int'(out_hs_pol ? e_hs : !e_hs));
         check(out_vs === (out_vs_pol ? e_vs : !e_vs), "R4 R6", int'(out_vs), int'(out_vs_pol ? e_vs : !e_vs));
         check(href_o === e_vis, "R8 href", int'(href_o), int'(e_vis));
         check(cap_o === e_cap, "R8 cap", int'(cap_o), int'(e_cap));
         check(border_o === e_brd, "R8 border", int'(border_o), int'(e_brd));
         check(int'(vtot_o) == vtm, "R11", int'(vtot_o), vtm);
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive_frame(input int hlen, input int lines, input bit hs_on, input bit vs_on);
      for (int l = 0; l < lines; l++) begin
         for (int c = 0; c < hlen; c++) begin
            bit ah, av;
            @(posedge clk); #1;
            ah = hs_on && (c < 2);
            av = vs_on && (l == 0) && (c < 4);
            in_hs = in_hs_pol ? ah : !ah;
            in_vs = in_vs_pol ? av : !av;
         end
      end
   endtask

   task automatic set_pols(input bit ihp, input bit ivp, input bit ohp, input bit ovp);
      in_hs_pol = ihp; in_hs = !ihp;
      in_vs_pol = ivp; in_vs = !ivp;
      out_hs_pol = ohp; out_vs_pol = ovp;
   endtask

   task automatic rand_cfg(output int htot);
      c_hth = 8'(6 + $urandom % 10);
      c_htl = 2'($urandom % 4);
      c_hcs = 8'($urandom % (int'(c_hth) + 1)); c_hce = 8'($urandom % (int'(c_hth) + 1));
      c_hss = 8'($urandom % (int'(c_hth) + 1)); c_hse = 8'($urandom % (int'(c_hth) + 1));
      c_hvs = 8'($urandom % (int'(c_hth) + 1)); c_hve = 8'($urandom % (int'(c_hth) + 1));
      c_vcs = 8'($urandom % 9); c_vce = 8'($urandom % 9);
      c_vss = 8'($urandom % 9); c_vse = 8'($urandom % 9);
      c_vvs = 8'($urandom % 9); c_vve = 8'($urandom % 9);
      htot = int'(c_hth) * 8 + int'(c_htl) * 2;
   endtask

   initial begin
      int ht;
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      soft_time = 1'b0; mode_sel = 2'd0;
      set_pols(1'b1, 1'b1, 1'b0, 1'b1);
      c_hcs = 0; c_hce = 0; c_hss = 0; c_hse = 0; c_hvs = 0; c_hve = 0;
      c_hth = 0; c_htl = 0; c_vcs = 0; c_vce = 0; c_vss = 0; c_vse = 0;
      c_vvs = 0; c_vve = 0;
      repeat (4) @(posedge clk);
      #1;
      // R1 reset state
      check(out_hs === 1'b1, "R1 out_hs", int'(out_hs), 1);
      check(out_vs === 1'b0, "R1 out_vs", int'(out_vs), 0);
      check(href_o === 1'b0, "R1 href", int'(href_o), 0);
      check(cap_o === 1'b0, "R1 cap", int'(cap_o), 0);
      check(border_o === 1'b0, "R1 border", int'(border_o), 0);
      check(vtot_o === 10'd0, "R1 vtot", int'(vtot_o), 0);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // R9 preset 0, long enough to reach capture lines
      cur_tag = "R9 ccir-ntsc";
      drive_frame(858, 55, 1'b1, 1'b1);
      drive_frame(858, 2, 1'b1, 1'b1);
      @(negedge clk);
      check(vtot_o == 10'd55, "R11 measured 55 lines", int'(vtot_o), 55);

      // R10 mode change mid-frame: old timing must persist until next frame edge
      cur_tag = "R10 mid-frame mode";
      drive_frame(858, 1, 1'b1, 1'b1);
      mode_sel = 2'd2;
      drive_frame(858, 2, 1'b1, 1'b0);
      // R5 square NTSC preset has a wrapping sync window
      cur_tag = "R5 R9 sq-ntsc";
      drive_frame(780, 4, 1'b1, 1'b1);
      cur_tag = "R9 ccir-pal";
      mode_sel = 2'd1;
      drive_frame(864, 4, 1'b1, 1'b1);
      cur_tag = "R9 sq-pal";
      mode_sel = 2'd3;
      drive_frame(944, 4, 1'b1, 1'b1);

      // random soft timing, polarities and register rewrites mid-frame
      cur_tag = "R3 R5 R6 R7 R10 random";
      soft_time = 1'b1;
      for (int f = 0; f < 25; f++) begin
         int lines, hlen;
         bit hs_on;
         rand_cfg(ht);
         set_pols(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
         lines = 20 + int'($urandom % 12);
         hlen  = ($urandom % 4 == 0) ? ht + 5 : ht;
         hs_on = ($urandom % 5 != 0);
         drive_frame(hlen, lines / 2, hs_on, 1'b1);
         if ($urandom % 2 == 1) rand_cfg(ht);
         drive_frame(hlen, lines - lines / 2, hs_on, 1'b0);
      end

      // R5 equal start and end gives an empty sync window
      cur_tag = "R5 empty window";
      c_hth = 8'd8; c_htl = 2'd1; c_hss = 8'd3; c_hse = 8'd3;
      c_hcs = 8'd1; c_hce = 8'd6; c_hvs = 8'd0; c_hve = 8'd7;
      c_vss = 8'd2; c_vse = 8'd2; c_vcs = 8'd1; c_vce = 8'd3; c_vvs = 8'd0; c_vve = 8'd4;
      drive_frame(66, 3, 1'b1, 1'b1);
      drive_frame(66, 20, 1'b1, 1'b1);

      // R3 free-running line counter with no input line sync
      cur_tag = "R3 free-run";
      c_hss = 8'd7; c_hse = 8'd1;
      drive_frame(70, 1, 1'b1, 1'b1);
      drive_frame(70, 20, 1'b0, 1'b1);
      drive_frame(70, 2, 1'b0, 1'b1);

      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule